// File: doc/BRIEF.md
# MSI Coherent L1 Cache Controller

This block is the child-side coherence engine of a small direct-mapped L1 cache. Each line holds one word. For each line the engine keeps an owner address, an MSI state, a pending-wait field that names the state it is waiting to be granted, and the data word. It answers processor loads and stores that hit. When an access misses, it asks the parent for the state it needs and holds the access until the grant arrives. It services downgrade requests from the parent, drops requests that have already been served, and lets a line be given up voluntarily through an evict input.

Processor requests enter a small queue and stay at its head until they complete, so the cache is blocking. Parent traffic arrives on one stream and is split into a request queue and a response queue. Responses are always applied first. A downgrade request that needs a reply but has no room in the outgoing queue waits at the head of its queue. It does not hold up processor hits or responses while it waits. Every message sent to the parent passes through an outgoing queue with a valid/ready handshake.

State encoding on all ports: I = 0, S = 1, M = 2. Message kind: 0 = request, 1 = response. The line index is the low address bits.

Top module: `msi_l1_ctrl`

## Requirements
- R1: After reset every line is in I with no pending wait, and no message or processor response is produced until stimulus arrives.
- R2: A load to a line in S or M returns the stored word, with cpu_rsp_valid asserted in the cycle the request leaves the queue. A store hits only in M, writes the word and returns an acknowledge (cpu_rsp_store = 1, cpu_rsp_rdata = 0). Neither kind of hit sends any message.
- R3: A load miss on a line in I sends a request (kind 0) for S carrying zero data. The load receives no response until the grant arrives.
- R4: A store to a line in I or S sends a request for M.
- R5: While a parent grant is pending, no further request is sent, even if more processor accesses are queued behind the stalled one.
- R6: An upgrade response writes its data only if the line was in I for that address. It then sets the line to the granted state and clears the wait, after which the stalled access completes.
- R7: A parent request to downgrade to y, for a line whose state is above y, produces a response (kind 1) with state y and moves the line to y. The response carries the line data when the line was in M and zero otherwise. The outgoing message stays stable while up_ready is low.
- R8: A parent downgrade request to y, for a line whose state is already at or below y, is removed from its queue with no reply and no change.
- R9: An evict to target y sends an unsolicited response to y (data only from M) when the line has no pending wait and its state is above y. In every other case it has no effect.
- R10: Parent responses are applied even while a downgrade request is blocked because the outgoing queue is full, and processor hits still proceed.
- R11: A miss on an index held by a different address in S or M first sends a response for the old address to I, with data if the old line was in M. The request for the new address follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request queue has room |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 8 | Processor address |
| cpu_req_wdata | input | 16 | Store data |
| cpu_rsp_valid | output | 1 | Processor response pulse |
| cpu_rsp_store | output | 1 | Response is a store acknowledge |
| cpu_rsp_rdata | output | 16 | Load data (zero on acknowledge) |
| evict_valid | input | 1 | Voluntary downgrade command valid |
| evict_ready | output | 1 | Evict command accepted this cycle |
| evict_addr | input | 8 | Address to give up |
| evict_to | input | 2 | Target state of the evict |
| up_valid | output | 1 | Message to parent valid |
| up_ready | input | 1 | Parent accepts the message |
| up_is_resp | output | 1 | Message kind (1 = response) |
| up_addr | output | 8 | Message address |
| up_state | output | 2 | Requested or new state |
| up_data | output | 16 | Message data |
| dn_valid | input | 1 | Message from parent valid |
| dn_ready | output | 1 | Queue for this kind has room |
| dn_is_resp | input | 1 | Message kind (1 = response) |
| dn_addr | input | 8 | Message address |
| dn_state | input | 2 | Granted or target state |
| dn_data | input | 16 | Grant data |

## Verification
The bench targets the places where coherence engines usually go wrong. A cache that repeats a request while waiting would show extra outgoing messages behind a stalled store. A cache that answers a stale downgrade would show an unrequested response, and one that stalls on it would never raise the next miss. An evict issued while a grant is pending must stay silent. A conflict miss must write back the old owner's dirty word before it asks for the new line. With the outgoing path blocked, a grant must still reach the processor, or the design deadlocks behind its own downgrade reply.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        MSI_I = 2'd0,
        MSI_S = 2'd1,
        MSI_M = 2'd2
    } msi_e;

    typedef enum logic {
        MSG_REQ  = 1'b0,
        MSG_RESP = 1'b1
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        msi_e               st;
        logic [DATA_W-1:0]  data;
    } coh_msg_t;

    typedef struct packed {
        logic               store;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
    } cpu_op_t;

    typedef struct packed {
        logic  pend;
        msi_e  want;
    } wait_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  owner;
        msi_e               st;
        wait_t              wt;
        logic [DATA_W-1:0]  data;
    } line_t;

    function automatic logic st_above(input msi_e a, input msi_e b);
        return a > b;
    endfunction

    function automatic msi_e eff_state(input line_t l, input logic [ADDR_W-1:0] a);
        return (l.owner == a) ? l.st : MSI_I;
    endfunction

    function automatic coh_msg_t make_resp(input logic [ADDR_W-1:0] a, input msi_e to,
                                           input logic [DATA_W-1:0] d, input msi_e from);
        coh_msg_t m;
        m.kind = MSG_RESP;
        m.addr = a;
        m.st   = to;
        m.data = (from == MSI_M) ? d : '0;
        return m;
    endfunction

    function automatic coh_msg_t make_req(input logic [ADDR_W-1:0] a, input msi_e want);
        coh_msg_t m;
        m.kind = MSG_REQ;
        m.addr = a;
        m.st   = want;
        m.data = '0;
        return m;
    endfunction

endpackage

// File: rtl/msi_fifo.sv
module msi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] dout
);
    // DEPTH must be a power of two, at least 2
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign dout    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/msi_lines.sv
module msi_lines
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    localparam int N    = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  line_t            wline,
    output line_t            lines [N]
);
    for (genvar g = 0; g < N; g++) begin : g_line
        line_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (widx == IDX_W'(g)))
                q <= wline;
        end
        assign lines[g] = q;
    end
endmodule

// File: rtl/msi_engine.sv
module msi_engine
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    localparam int N    = 1 << IDX_W
) (
    input  line_t             lines [N],
    input  coh_msg_t          resp_head,
    input  logic              resp_empty,
    input  coh_msg_t          req_head,
    input  logic              req_empty,
    input  cpu_op_t           cpu_head,
    input  logic              cpu_empty,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [1:0]        evict_to,
    input  logic              out_full,
    output logic              resp_pop,
    output logic              req_pop,
    output logic              cpu_pop,
    output logic              evict_ready,
    output logic              out_push,
    output coh_msg_t          out_msg,
    output logic              we,
    output logic [IDX_W-1:0]  widx,
    output line_t             wline,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_store,
    output logic [DATA_W-1:0] cpu_rsp_rdata
);
    line_t rs_line, rq_line, ev_line, cp_line;
    msi_e  rs_cur, rq_cur, ev_cur, cp_cur, cp_want, ev_to;
    logic  rq_reply, rq_act, ev_slot, cp_hit;
    logic [IDX_W-1:0] rs_idx, rq_idx, ev_idx, cp_idx;

    always_comb begin
        rs_idx  = resp_head.addr[IDX_W-1:0];
        rq_idx  = req_head.addr[IDX_W-1:0];
        ev_idx  = evict_addr[IDX_W-1:0];
        cp_idx  = cpu_head.addr[IDX_W-1:0];
        rs_line = lines[rs_idx];
        rq_line = lines[rq_idx];
        ev_line = lines[ev_idx];
        cp_line = lines[cp_idx];
        rs_cur  = eff_state(rs_line, resp_head.addr);
        rq_cur  = eff_state(rq_line, req_head.addr);
        ev_cur  = eff_state(ev_line, evict_addr);
        cp_cur  = eff_state(cp_line, cpu_head.addr);
        ev_to   = msi_e'(evict_to);
        // a downgrade needing a reply waits for outgoing room; a drop never waits
        rq_reply = st_above(rq_cur, req_head.st);
        rq_act   = !req_empty && (!rq_reply || !out_full);
        ev_slot  = resp_empty && !rq_act && !out_full;
        cp_want  = cpu_head.store ? MSI_M : MSI_S;
        cp_hit   = cpu_head.store ? (cp_cur == MSI_M) : (cp_cur != MSI_I);
    end

    assign evict_ready = ev_slot;

    always_comb begin
        resp_pop      = 1'b0;
        req_pop       = 1'b0;
        cpu_pop       = 1'b0;
        out_push      = 1'b0;
        out_msg       = '0;
        we            = 1'b0;
        widx          = '0;
        wline         = '0;
        cpu_rsp_valid = 1'b0;
        cpu_rsp_store = 1'b0;
        cpu_rsp_rdata = '0;

        if (!resp_empty) begin
            // grant from parent: always accepted
            resp_pop = 1'b1;
            we       = 1'b1;
            widx     = rs_idx;
            wline    = rs_line;
            if (rs_cur == MSI_I) wline.data = resp_head.data;
            wline.owner = resp_head.addr;
            wline.st    = resp_head.st;
            wline.wt    = '0;
        end else if (rq_act) begin
            req_pop = 1'b1;
            if (rq_reply) begin
                out_push = 1'b1;
                out_msg  = make_resp(req_head.addr, req_head.st, rq_line.data, rq_cur);
                we       = 1'b1;
                widx     = rq_idx;
                wline    = rq_line;
                wline.st = req_head.st;
            end
        end else if (evict_valid && ev_slot) begin
            if (!ev_line.wt.pend && st_above(ev_cur, ev_to)) begin
                out_push = 1'b1;
                out_msg  = make_resp(evict_addr, ev_to, ev_line.data, ev_cur);
                we       = 1'b1;
                widx     = ev_idx;
                wline    = ev_line;
                wline.st = ev_to;
            end
        end else if (!cpu_empty) begin
            if (cp_hit) begin
                cpu_pop       = 1'b1;
                cpu_rsp_valid = 1'b1;
                cpu_rsp_store = cpu_head.store;
                if (cpu_head.store) begin
                    we         = 1'b1;
                    widx       = cp_idx;
                    wline      = cp_line;
                    wline.data = cpu_head.wdata;
                end else begin
                    cpu_rsp_rdata = cp_line.data;
                end
            end else if (!cp_line.wt.pend && !out_full) begin
                we    = 1'b1;
                widx  = cp_idx;
                wline = cp_line;
                out_push = 1'b1;
                if ((cp_line.owner != cpu_head.addr) && (cp_line.st != MSI_I)) begin
                    // conflict: give up the old owner first
                    out_msg  = make_resp(cp_line.owner, MSI_I, cp_line.data, cp_line.st);
                    wline.st = MSI_I;
                end else begin
                    out_msg     = make_req(cpu_head.addr, cp_want);
                    wline.owner = cpu_head.addr;
                    wline.st    = cp_cur;
                    wline.wt    = '{pend: 1'b1, want: cp_want};
                end
            end
        end
    end
endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_store,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic              cpu_rsp_store,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    input  logic              evict_valid,
    output logic              evict_ready,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [1:0]        evict_to,
    output logic              up_valid,
    input  logic              up_ready,
    output logic              up_is_resp,
    output logic [ADDR_W-1:0] up_addr,
    output logic [1:0]        up_state,
    output logic [DATA_W-1:0] up_data,
    input  logic              dn_valid,
    output logic              dn_ready,
    input  logic              dn_is_resp,
    input  logic [ADDR_W-1:0] dn_addr,
    input  logic [1:0]        dn_state,
    input  logic [DATA_W-1:0] dn_data
);
    localparam int N     = 1 << IDX_W;
    localparam int MSG_W = $bits(coh_msg_t);
    localparam int OP_W  = $bits(cpu_op_t);

    cpu_op_t  cpu_in, cpu_head;
    coh_msg_t dn_msg, resp_head, req_head, out_msg, up_msg;
    logic [OP_W-1:0]  cpu_dout;
    logic [MSG_W-1:0] resp_dout, req_dout, up_dout;
    logic cpu_full, cpu_empty, cpu_pop;
    logic resp_full, resp_empty, resp_pop;
    logic req_full, req_empty, req_pop;
    logic out_full, out_empty, out_push;
    logic we;
    logic [IDX_W-1:0] widx;
    line_t wline;
    line_t line_q [N];
    logic chk_req_push, chk_any_pend;

    assign cpu_in  = '{store: cpu_req_store, addr: cpu_req_addr, wdata: cpu_req_wdata};
    assign dn_msg  = '{kind: kind_e'(dn_is_resp), addr: dn_addr, st: msi_e'(dn_state), data: dn_data};
    assign cpu_req_ready = !cpu_full;
    assign dn_ready      = dn_is_resp ? !resp_full : !req_full;

    msi_fifo #(.W(OP_W), .DEPTH(QDEPTH)) i_cpu_q (
        .clk, .rst, .push(cpu_req_valid), .din(cpu_in), .pop(cpu_pop),
        .full(cpu_full), .empty(cpu_empty), .dout(cpu_dout));

    msi_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) i_resp_q (
        .clk, .rst, .push(dn_valid && dn_is_resp), .din(dn_msg), .pop(resp_pop),
        .full(resp_full), .empty(resp_empty), .dout(resp_dout));

    msi_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) i_req_q (
        .clk, .rst, .push(dn_valid && !dn_is_resp), .din(dn_msg), .pop(req_pop),
        .full(req_full), .empty(req_empty), .dout(req_dout));

    msi_fifo #(.W(MSG_W), .DEPTH(QDEPTH)) i_up_q (
        .clk, .rst, .push(out_push), .din(out_msg), .pop(up_valid && up_ready),
        .full(out_full), .empty(out_empty), .dout(up_dout));

    assign cpu_head  = cpu_op_t'(cpu_dout);
    assign resp_head = coh_msg_t'(resp_dout);
    assign req_head  = coh_msg_t'(req_dout);
    assign up_msg    = coh_msg_t'(up_dout);

    assign up_valid   = !out_empty;
    assign up_is_resp = (up_msg.kind == MSG_RESP);
    assign up_addr    = up_msg.addr;
    assign up_state   = up_msg.st;
    assign up_data    = up_msg.data;

    msi_lines #(.IDX_W(IDX_W)) i_lines (
        .clk, .rst, .we, .widx, .wline, .lines(line_q));

    msi_engine #(.IDX_W(IDX_W)) i_engine (
        .lines(line_q), .resp_head, .resp_empty, .req_head, .req_empty,
        .cpu_head, .cpu_empty, .evict_valid, .evict_addr, .evict_to, .out_full,
        .resp_pop, .req_pop, .cpu_pop, .evict_ready, .out_push, .out_msg,
        .we, .widx, .wline, .cpu_rsp_valid, .cpu_rsp_store, .cpu_rsp_rdata);

    // observation points for the bound checker
    assign chk_req_push = out_push && (out_msg.kind == MSG_REQ);
    always_comb begin
        chk_any_pend = 1'b0;
        for (int i = 0; i < N; i++) chk_any_pend = chk_any_pend | line_q[i].wt.pend;
    end
endmodule

// File: rtl/msi_l1_chk.sv
module msi_l1_chk
    import msi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_ready,
    input logic              up_is_resp,
    input logic [ADDR_W-1:0] up_addr,
    input logic [1:0]        up_state,
    input logic [DATA_W-1:0] up_data,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_store,
    input logic [DATA_W-1:0] cpu_rsp_rdata,
    input logic              resp_empty,
    input logic              resp_pop,
    input logic              chk_req_push,
    input logic              chk_any_pend
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!up_valid && !cpu_rsp_valid)); // R1

    AST_ACK_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (cpu_rsp_valid && cpu_rsp_store) |-> (cpu_rsp_rdata == '0)); // R2

    AST_REQ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_is_resp) |-> (up_data == '0 && up_state != 2'd0)); // R3

    AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        chk_req_push |-> !chk_any_pend); // R5

    AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_ready) |=>
            (up_valid && $stable({up_is_resp, up_addr, up_state, up_data}))); // R7

    AST_STATE_CODE: assert property (@(posedge clk) disable iff (rst)
        up_valid |-> (up_state != 2'd3)); // R7

    AST_RESP_DRAINS: assert property (@(posedge clk) disable iff (rst)
        !resp_empty |-> resp_pop); // R10
endmodule

bind msi_l1_ctrl msi_l1_chk i_chk (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_ready(up_ready), .up_is_resp(up_is_resp),
    .up_addr(up_addr), .up_state(up_state), .up_data(up_data),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_store(cpu_rsp_store),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .resp_empty(resp_empty), .resp_pop(resp_pop),
    .chk_req_push(chk_req_push), .chk_any_pend(chk_any_pend));

// File: tb/test_msi_l1_ctrl.sv
module test_msi_l1_ctrl;
    localparam int CLK_P = 10;
    localparam logic [7:0] A = 8'h10, B = 8'h14, C = 8'h21;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req_valid = 0, cpu_req_store = 0;
    logic [7:0] cpu_req_addr = 0;
    logic [15:0] cpu_req_wdata = 0;
    logic cpu_req_ready, cpu_rsp_valid, cpu_rsp_store;
    logic [15:0] cpu_rsp_rdata;
    logic evict_valid = 0, evict_ready;
    logic [7:0] evict_addr = 0;
    logic [1:0] evict_to = 0;
    logic up_valid, up_ready = 1, up_is_resp;
    logic [7:0] up_addr;
    logic [1:0] up_state;
    logic [15:0] up_data;
    logic dn_valid = 0, dn_ready, dn_is_resp = 0;
    logic [7:0] dn_addr = 0;
    logic [1:0] dn_state = 0;
    logic [15:0] dn_data = 0;

    int n_chk = 0, n_fail = 0, n_up = 0, n_rsp = 0;
    logic [26:0] up_log [64];
    logic [16:0] rsp_log [64];
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    msi_l1_ctrl i_msi_l1_ctrl (.*);

    // handshakes observed with pre-edge values
    always @(posedge clk) begin
        if (!rst) begin
            if (up_valid && up_ready) begin
                up_log[n_up % 64] = {up_is_resp, up_addr, up_state, up_data};
                n_up++;
            end
            if (cpu_rsp_valid) begin
                rsp_log[n_rsp % 64] = {cpu_rsp_store, cpu_rsp_rdata};
                n_rsp++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_up(input string tag, input int i, input logic k, input logic [7:0] a,
                          input logic [1:0] s, input logic [15:0] d);
        chk(tag, 32'(up_log[i % 64]), 32'({k, a, s, d}));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_op(input logic st, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_store = st; cpu_req_addr = a; cpu_req_wdata = d;
        do @(posedge clk); while (!cpu_req_ready);
        @(negedge clk);
        cpu_req_valid = 0;
    endtask

    task automatic parent(input logic r, input logic [7:0] a, input logic [1:0] s,
                          input logic [15:0] d);
        @(negedge clk);
        dn_valid = 1; dn_is_resp = r; dn_addr = a; dn_state = s; dn_data = d;
        do @(posedge clk); while (!dn_ready);
        @(negedge clk);
        dn_valid = 0;
    endtask

    task automatic evict(input logic [7:0] a, input logic [1:0] to);
        @(negedge clk);
        evict_valid = 1; evict_addr = a; evict_to = to;
        do @(posedge clk); while (!evict_ready);
        @(negedge clk);
        evict_valid = 0;
    endtask

    task automatic t_reset;
        idle(2);
        chk("R1 up_valid", 32'(up_valid), 0);
        chk("R1 cpu_rsp_valid", 32'(cpu_rsp_valid), 0);
        chk("R1 ready", 32'({cpu_req_ready, evict_ready}), 32'b11);
        evict(A, 2'd0);
        idle(3);
        chk("R1 evict on I line silent", 32'(n_up), 0);
    endtask

    task automatic t_load_miss;
        int b = n_up, r = n_rsp;
        cpu_op(0, A, 0);
        idle(5);
        chk("R3 one request", 32'(n_up - b), 1);
        chk_up("R3 request for S", b, 0, A, 2'd1, 0);
        chk("R3 load held", 32'(n_rsp - r), 0);
        parent(1, A, 2'd1, 16'h1234);
        idle(4);
        chk("R6 fill data", 32'(rsp_log[r % 64]), 32'({1'b0, 16'h1234}));
        cpu_op(0, A, 0);
        idle(3);
        chk("R2 load hit in S", 32'(rsp_log[(r + 1) % 64]), 32'({1'b0, 16'h1234}));
        chk("R2 hit sends nothing", 32'(n_up - b), 1);
    endtask

    task automatic t_store_upgrade;
        int b = n_up, r = n_rsp;
        cpu_op(1, A, 16'hBEEF);
        idle(5);
        chk_up("R4 request for M", b, 0, A, 2'd2, 0);
        cpu_op(0, A, 0);
        idle(6);
        chk("R5 single outstanding", 32'(n_up - b), 1);
        chk("R5 nothing answered", 32'(n_rsp - r), 0);
        parent(1, A, 2'd2, 16'h5555);
        idle(5);
        chk("R2 store ack", 32'(rsp_log[r % 64]), 32'({1'b1, 16'h0}));
        chk("R6 load after grant", 32'(rsp_log[(r + 1) % 64]), 32'({1'b0, 16'hBEEF}));
    endtask

    task automatic t_downgrade;
        int b = n_up;
        parent(0, A, 2'd1, 0);
        idle(4);
        chk_up("R7 M to S with data", b, 1, A, 2'd1, 16'hBEEF);
        parent(0, A, 2'd0, 0);
        idle(4);
        chk_up("R7 S to I without data", b + 1, 1, A, 2'd0, 0);
        chk("R7 two replies", 32'(n_up - b), 2);
    endtask

    task automatic t_stale;
        int b = n_up, r = n_rsp;
        parent(0, A, 2'd0, 0);
        parent(0, A, 2'd1, 0);
        parent(0, C, 2'd0, 0);
        idle(6);
        chk("R8 stale dropped silently", 32'(n_up - b), 0);
        cpu_op(0, A, 0);
        idle(5);
        chk_up("R8 line stayed I, queue drained", b, 0, A, 2'd1, 0);
        parent(1, A, 2'd1, 16'h2222);
        idle(4);
        chk("R6 refill", 32'(rsp_log[r % 64]), 32'({1'b0, 16'h2222}));
    endtask

    task automatic t_voluntary;
        int b = n_up, r = n_rsp;
        cpu_op(1, A, 16'h3333);
        idle(5);
        chk_up("R4 S to M request", b, 0, A, 2'd2, 0);
        evict(A, 2'd0);
        idle(4);
        chk("R9 evict ignored while waiting", 32'(n_up - b), 1);
        parent(1, A, 2'd2, 16'h9999);
        idle(4);
        chk("R2 store ack after grant", 32'(rsp_log[r % 64]), 32'({1'b1, 16'h0}));
        evict(A, 2'd1);
        idle(4);
        chk_up("R9 M to S with data", b + 1, 1, A, 2'd1, 16'h3333);
        evict(A, 2'd1);
        idle(4);
        chk("R9 repeat evict has no effect", 32'(n_up - b), 2);
        evict(A, 2'd0);
        idle(4);
        chk_up("R9 S to I without data", b + 2, 1, A, 2'd0, 0);
    endtask

    task automatic t_conflict;
        int b, r;
        cpu_op(1, A, 16'h4444);
        idle(4);
        parent(1, A, 2'd2, 16'h0);
        idle(4);
        b = n_up; r = n_rsp;
        cpu_op(1, B, 16'h7777);
        idle(6);
        chk_up("R11 old owner written back", b, 1, A, 2'd0, 16'h4444);
        chk_up("R11 then request for new", b + 1, 0, B, 2'd2, 0);
        parent(1, B, 2'd2, 16'h0);
        idle(4);
        cpu_op(0, B, 0);
        idle(4);
        chk("R11 new line usable", 32'(rsp_log[(r + 1) % 64]), 32'({1'b0, 16'h7777}));
    endtask

    task automatic t_priority;
        int b, r;
        @(negedge clk);
        up_ready = 0;
        b = n_up; r = n_rsp;
        cpu_op(0, C, 0);
        idle(3);
        evict(B, 2'd1);
        idle(3);
        parent(0, B, 2'd0, 0);
        parent(1, C, 2'd1, 16'hC0C0);
        idle(5);
        chk("R10 grant applied while blocked", 32'(n_rsp - r), 1);
        chk("R10 load data", 32'(rsp_log[r % 64]), 32'({1'b0, 16'hC0C0}));
        chk("R10 nothing left yet", 32'(n_up - b), 0);
        @(negedge clk);
        up_ready = 1;
        idle(6);
        chk("R10 all three sent", 32'(n_up - b), 3);
        chk_up("R10 request first", b, 0, C, 2'd1, 0);
        chk_up("R10 evict reply", b + 1, 1, B, 2'd1, 16'h7777);
        chk_up("R10 blocked downgrade", b + 2, 1, B, 2'd0, 0);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_load_miss();
        t_store_upgrade();
        t_downgrade();
        t_stale();
        t_voluntary();
        t_conflict();
        t_priority();
        done = 1;
        finish_up();
    end
endmodule